// File: doc/BRIEF.md
# Parallel ADC Read Controller

This block is the host side of a handshake with an 8-channel, 8-bit converter whose results come out on a parallel bus. A client sends a channel request on a valid/ready stream. The block then drives the converter's multiplexer address and its active-low chip-select and read strobes. It watches the converter's open-drain ready line and its active-low interrupt line. The 8-bit result goes back on a second valid/ready stream, together with a channel tag, a stale flag and an error flag. All analog timing is given in clock cycles through parameters.

There are two protocols, and each request picks one with `req_pipe`. In blocking mode (`req_pipe`=0), the strobes stay low until the converter reports that the conversion is done. The data is then taken from that same read. In overlapped mode (`req_pipe`=1), every strobe pulse has a fixed width. Each pulse returns the conversion started by the previous pulse and also starts a new one. The block therefore carries the channel of the previous overlapped read and returns it as the tag. It also holds the strobes off until a minimum time has passed since the last overlapped pulse. A flush request makes one overlapped read on a dummy channel, which collects the last outstanding result.

Back-pressure works as follows. A request moves only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle with no response waiting. A response, once offered, stays on the port unchanged until `rsp_ready` takes it.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and right after reset, `adc_cs_n` and `adc_rd_n` are high, `rsp_valid` is low and `req_ready` is high.
- R2: A request is accepted only when `req_ready` is high, and `req_ready` is high only while the strobes are idle. `adc_addr` takes the requested channel at acceptance and is held for at least T_AS cycles before `adc_cs_n` and `adc_rd_n` fall together in the same cycle. It stays unchanged for as long as they are low.
- R3: In blocking mode, the strobes stay low until a cycle in which `adc_rdy` is high and `adc_int_n` is low. `adc_db` is sampled in that cycle. The response carries that byte, the requested channel, stale=0 and err=0.
- R4: In blocking mode, if completion has not been seen after T_TMO cycles with the strobes low, the strobes go high and the response has err=1.
- R5: In overlapped mode, the strobes stay low for exactly T_RD cycles, and `adc_db` is sampled in the last of those cycles.
- R6: In overlapped mode, `rsp_chan` is the channel of the previous overlapped read. stale=1 marks the first overlapped read after reset, after a request whose mode differs from the one before it, or after a flush.
- R7: Between the rising edge of the strobes after an overlapped read and their next falling edge in overlapped mode, at least T_GAP cycles pass.
- R8: A request with `req_flush`=1 and `req_pipe`=1 drives channel 0 on `adc_addr`. Its response carries the channel of the previous overlapped read, and the next overlapped read is marked stale. With `req_pipe`=0, `req_flush` has no effect: the requested channel is used.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, the response fields do not change and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_chan | input | 3 | Channel to convert |
| req_pipe | input | 1 | 1 = overlapped protocol, 0 = blocking protocol |
| req_flush | input | 1 | Overlapped dummy read to collect the pending result |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Client takes the response |
| rsp_data | output | 8 | Converted byte |
| rsp_chan | output | 3 | Channel the byte belongs to |
| rsp_stale | output | 1 | Byte belongs to no tracked request |
| rsp_err | output | 1 | Blocking read timed out |
| adc_addr | output | 3 | Multiplexer address to the converter |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_rdy | input | 1 | Open-drain ready (high = released) |
| adc_int_n | input | 1 | Conversion-done interrupt, active low |
| adc_db | input | 8 | Converter data bus |

## Verification
The bench builds the block with T_AS=2, T_RD=3, T_GAP=6 and T_TMO=12, and puts it against a converter model that finishes in 5 cycles. With these values, every channel in both modes, every mode change, flush and timeout fits in a few hundred cycles. Because the model's conversion outlasts the overlapped pulse but ends inside the spacing window, the overlapped data really does belong to the earlier request. The expected bytes encode a conversion count and the channel, so a wrong tag or a wrong read shows up as a different byte.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_LOW, ST_RESP} rd_st_t;

  typedef struct packed {
    logic [7:0] data;
    logic [2:0] chan;
    logic       stale;
    logic       err;
  } rd_rsp_t;
endpackage

// File: rtl/adc_rd_gap.sv
module adc_rd_gap #(
  parameter int T_GAP = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);
  localparam int GW = $clog2(T_GAP + 1);

  logic [GW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           left_q <= '0;
    else if (load)        left_q <= GW'(T_GAP);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign zero = (left_q == '0);

  // R7
  gap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !zero);
endmodule

// File: rtl/adc_rd_tag.sv
module adc_rd_tag #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            upd,
  input  logic            flush,
  input  logic [CH_W-1:0] new_chan,
  output logic [CH_W-1:0] prev_chan,
  output logic            pv
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_chan <= '0;
      pv        <= 1'b0;
    end else if (clr) begin
      pv        <= 1'b0;
    end else if (upd) begin
      prev_chan <= new_chan;
      pv        <= !flush;
    end
  end

  // R6
  tag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pv);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int CH_W  = 3,
  parameter int D_W   = 8,
  parameter int T_AS  = 25,
  parameter int T_RD  = 30,
  parameter int T_GAP = 125,
  parameter int T_TMO = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [CH_W-1:0] req_chan,
  input  logic            req_pipe,
  input  logic            req_flush,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [D_W-1:0]  rsp_data,
  output logic [CH_W-1:0] rsp_chan,
  output logic            rsp_stale,
  output logic            rsp_err,
  output logic [CH_W-1:0] adc_addr,
  output logic            adc_cs_n,
  output logic            adc_rd_n,
  input  logic            adc_rdy,
  input  logic            adc_int_n,
  input  logic [D_W-1:0]  adc_db
);
  import adc_rd_pkg::*;

  localparam int MAX_AR = (T_AS > T_RD) ? T_AS : T_RD;
  localparam int MAXT   = (MAX_AR > T_TMO) ? MAX_AR : T_TMO;
  localparam int CW     = $clog2(MAXT + 1);

  rd_st_t          st_q;
  logic [CW-1:0]   cnt_q;
  logic [CH_W-1:0] chan_q, addr_q;
  logic            mode_q, flush_q, strobe_n_q;
  rd_rsp_t         rsp_q;
  logic            gap_zero, pv;
  logic [CH_W-1:0] prev_chan;

  logic accept, flush_eff, mode_chg, done_w, tmo_w, pend_w, finish;

  assign accept    = req_valid && req_ready;
  assign flush_eff = req_flush && req_pipe;
  assign mode_chg  = accept && (req_pipe != mode_q);
  assign done_w    = (st_q == ST_LOW) && !mode_q && adc_rdy && !adc_int_n;
  assign tmo_w     = (st_q == ST_LOW) && !mode_q && !done_w && (cnt_q == CW'(T_TMO - 1));
  assign pend_w    = (st_q == ST_LOW) && mode_q && (cnt_q == CW'(T_RD - 1));
  assign finish    = done_w || tmo_w || pend_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      chan_q     <= '0;
      addr_q     <= '0;
      mode_q     <= 1'b0;
      flush_q    <= 1'b0;
      strobe_n_q <= 1'b1;
      rsp_q      <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          chan_q  <= req_chan;
          addr_q  <= flush_eff ? '0 : req_chan;
          mode_q  <= req_pipe;
          flush_q <= flush_eff;
          cnt_q   <= '0;
          st_q    <= ST_SETUP;
        end
        ST_SETUP: begin
          if ((cnt_q >= CW'(T_AS - 1)) && (!mode_q || gap_zero)) begin
            strobe_n_q <= 1'b0;
            cnt_q      <= '0;
            st_q       <= ST_LOW;
          end else if (cnt_q < CW'(T_AS - 1)) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOW: begin
          cnt_q <= cnt_q + 1'b1;
          if (finish) begin
            strobe_n_q  <= 1'b1;
            rsp_q.data  <= adc_db;
            rsp_q.chan  <= mode_q ? prev_chan : chan_q;
            rsp_q.stale <= mode_q && !pv;
            rsp_q.err   <= tmo_w;
            st_q        <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  adc_rd_gap #(.T_GAP(T_GAP)) gap_i (
    .clk(clk), .rst_n(rst_n), .load(pend_w), .zero(gap_zero)
  );

  adc_rd_tag #(.CH_W(CH_W)) tag_i (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .upd(pend_w),
    .flush(flush_q), .new_chan(chan_q), .prev_chan(prev_chan), .pv(pv)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_data  = rsp_q.data;
  assign rsp_chan  = rsp_q.chan;
  assign rsp_stale = rsp_q.stale;
  assign rsp_err   = rsp_q.err;
  assign adc_addr  = addr_q;
  assign adc_cs_n  = strobe_n_q;
  assign adc_rd_n  = strobe_n_q;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && !$past(adc_cs_n)) |-> $stable(adc_addr));

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (adc_cs_n && adc_rd_n));

  // R7
  gap_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(adc_cs_n) && mode_q) |-> gap_zero);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                   $stable(rsp_chan) && $stable(rsp_stale) && !req_ready));
endmodule

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;
  localparam int T_AS = 2, T_RD = 3, T_GAP = 6, T_TMO = 12, CONV = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_pipe = 1'b0, req_flush = 1'b0, rsp_ready = 1'b0;
  logic [2:0] req_chan = '0;
  logic req_ready, rsp_valid, rsp_stale, rsp_err, adc_cs_n, adc_rd_n;
  logic [7:0] rsp_data;
  logic [2:0] rsp_chan, adc_addr;
  logic adc_rdy, adc_int_n;
  logic [7:0] adc_db;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  adc_rd_ctrl #(.T_AS(T_AS), .T_RD(T_RD), .T_GAP(T_GAP), .T_TMO(T_TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_pipe(req_pipe), .req_flush(req_flush),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_chan(rsp_chan), .rsp_stale(rsp_stale), .rsp_err(rsp_err),
    .adc_addr(adc_addr), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_rdy(adc_rdy), .adc_int_n(adc_int_n), .adc_db(adc_db)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model, acting on falling clock edges
  logic tb_pipe = 1'b0, tb_dead = 1'b0;
  logic [7:0] m_k = '0, m_last = '0, m_out = '0;
  logic [2:0] m_addr = '0;
  logic m_busy = 1'b0, m_done = 1'b0, m_int = 1'b0, m_prev_cs = 1'b1;
  int m_tmr = 0;

  assign adc_rdy   = adc_cs_n | m_done;
  assign adc_int_n = ~m_int;
  assign adc_db    = tb_pipe ? m_out : m_last;

  always @(negedge clk) begin
    if (m_prev_cs && !adc_cs_n) begin
      m_k    <= m_k + 1'b1;
      m_addr <= adc_addr;
      m_out  <= m_last;
      m_busy <= 1'b1;
      m_tmr  <= 0;
      m_done <= 1'b0;
    end else begin
      if (!m_prev_cs && adc_cs_n) m_int <= 1'b0;
      if (m_busy) begin
        m_tmr <= m_tmr + 1;
        if (m_tmr == CONV - 1 && !tb_dead) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          m_int  <= 1'b1;
          m_last <= {m_k[4:0], m_addr};
        end
      end
    end
    m_prev_cs <= adc_cs_n;
  end

  // bus timing monitor
  logic b_prev_cs = 1'b1, b_last_pipe = 1'b0, b_seen_rel = 1'b0;
  logic [2:0] b_prev_addr = '0;
  int since_addr = 1000, low_len = 0, high_len = 1000;

  always @(negedge clk) if (rst_n) begin
    if (adc_addr != b_prev_addr) since_addr = 1;
    else if (since_addr < 1000) since_addr++;
    b_prev_addr = adc_addr;
    if (b_prev_cs && !adc_cs_n) begin
      chk("R2 setup", since_addr > T_AS, 1);
      chk("R2 strobes together", adc_rd_n, adc_cs_n);
      if (tb_pipe && b_last_pipe && b_seen_rel) chk("R7 spacing", high_len >= T_GAP, 1);
      low_len = 1;
    end else if (!b_prev_cs && adc_cs_n) begin
      if (tb_pipe) chk("R5 pulse width", low_len, T_RD);
      else if (tb_dead) chk("R4 timeout width", low_len, T_TMO);
      b_last_pipe = tb_pipe;
      b_seen_rel = 1'b1;
      high_len = 1;
    end else if (!adc_cs_n) low_len++;
    else high_len++;
    b_prev_cs = adc_cs_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // expected-state model of the request stream
  int k_exp = 0;
  logic [7:0] last_exp = '0;
  logic [2:0] prev_exp = '0;
  logic pv_exp = 1'b0, mode_exp = 1'b0;

  task automatic run(input logic [2:0] ch, input logic pipe, input logic fl,
                     input logic dead, input int hold);
    logic [2:0] a;
    logic [7:0] res, e_data, d0;
    logic [2:0] e_chan;
    logic e_stale, e_err, fe;
    fe = fl && pipe;
    a = fe ? 3'd0 : ch;
    k_exp++;
    res = {k_exp[4:0], a};
    if (pipe != mode_exp) pv_exp = 1'b0;
    mode_exp = pipe;
    if (pipe) begin
      e_data = last_exp; e_chan = prev_exp; e_stale = !pv_exp; e_err = 1'b0;
      last_exp = res; pv_exp = !fe; prev_exp = ch;
    end else begin
      e_data = res; e_chan = ch; e_stale = 1'b0; e_err = dead;
      if (!dead) last_exp = res;
    end
    @(negedge clk);
    tb_pipe = pipe; tb_dead = dead;
    req_valid = 1'b1; req_chan = ch; req_pipe = pipe; req_flush = fl;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 address", adc_addr, a);
    while (!rsp_valid) @(negedge clk);
    d0 = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R9 held valid", rsp_valid, 1);
      chk("R9 stable data", rsp_data, d0);
      chk("R9 no accept", req_ready, 0);
    end
    if (pipe) begin
      chk(fe ? "R8 flush data" : "R5 prior data", rsp_data, e_data);
      chk("R6 stale", rsp_stale, e_stale);
      if (!e_stale) chk(fe ? "R8 flush tag" : "R6 tag", rsp_chan, e_chan);
    end else begin
      chk(dead ? "R4 err" : "R3 err", rsp_err, e_err);
      if (!dead) begin
        chk(fl ? "R8 ignored flush" : "R3 data", rsp_data, e_data);
        chk("R3 tag", rsp_chan, e_chan);
        chk("R3 stale", rsp_stale, 0);
      end
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs", adc_cs_n, 1);
    chk("R1 rd", adc_rd_n, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 cs after", adc_cs_n, 1);
    for (int c = 0; c < 8; c++) run(3'(c), 1'b0, 1'b0, 1'b0, 0);
    for (int c = 0; c < 8; c++) run(3'(7 - c), 1'b1, 1'b0, 1'b0, 0);
    run(3'd3, 1'b0, 1'b0, 1'b0, 0);
    run(3'd4, 1'b1, 1'b0, 1'b0, 0);
    run(3'd6, 1'b1, 1'b0, 1'b0, 0);
    run(3'd5, 1'b1, 1'b1, 1'b0, 0);
    run(3'd1, 1'b1, 1'b0, 1'b0, 0);
    run(3'd2, 1'b1, 1'b0, 1'b0, 3);
    run(3'd5, 1'b0, 1'b1, 1'b0, 0);
    run(3'd2, 1'b0, 1'b0, 1'b1, 0);
    run(3'd7, 1'b0, 1'b0, 1'b0, 4);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule